// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Unit

This block sits beside the shift engine of an SPI peripheral. It holds two small byte queues: a receive queue filled by the shift engine and drained by the bus side, and a transmit queue filled by the bus side and drained by the shift engine. It keeps a fill count for each queue and a set of sticky event flags: receive overflow, transmit underflow, a receive-done flag and a transmit-done flag. It packs them with the counts into one 16-bit read-only status word.

A single interrupt line follows a global flag. Any enabled interrupt source sets this flag. The transfer-mode bit selects whether completion is judged on the receive side or on the transmit side. Each of two flush-mode bits keeps its queue's overflow or underflow event off the interrupt line, while the event is still recorded in the status word. A status-read strobe clears every sticky flag. The word is built from registered state, so every event is visible in the cycle after the clock edge that recorded it.

Top module: `spi_fifo_status`

## Requirements
- R1: After reset, `statusWord` is 0x0000, `irq` is 0 and both pop data outputs are 0x00.
- R2: Bits 10:8 of `statusWord` give the receive count and bits 3:1 give the transmit count, each a binary value from 0 to 4. Bits 15:12 always read 0. A push into a full queue with no pop in the same cycle is discarded, and the count stays at 4.
- R3: A receive push while the receive queue holds 4 bytes and no receive pop is present sets bit 7 (receive overflow). The stored bytes do not change.
- R4: A `xferStart` pulse while the transmit count is 0 sets bit 4 (transmit underflow).
- R5: Bit 11 (receive excess) is 1 exactly when the receive count is greater than `rxMark`. It is a level and is not sticky.
- R6: With `txMode`=0, an accepted receive push that leaves the receive count at or above a nonzero `rxMark` sets bit 6 (receive done). An `rxMark` of 0 never sets it.
- R7: With `txMode`=1, a transmit pop that leaves the transmit count at or below `txMark` sets bit 5 (transmit done).
- R8: Bit 0 (global interrupt) and `irq` go to 1 in the cycle after any of these events: receive done, transmit done, overflow while `rxFlush`=0, underflow while `txFlush`=0. An overflow while `rxFlush`=1 or an underflow while `txFlush`=1 still sets its own bit but does not set bit 0 or `irq`.
- R9: A `statRead` pulse clears bits 7, 6, 5, 4 and 0 after the clock edge. If a set event for a bit occurs in the same cycle as the read, that bit stays set.
- R10: A pop from an empty queue leaves the count at 0 and holds the pop data output. A push and a pop together on an empty queue pass the pushed byte straight to the pop data output and leave the count at 0. A push and a pop together on a non-empty queue leave the count unchanged.
- R11: Each queue returns bytes in the order they were written. A popped byte appears on the pop data output in the cycle after the pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxPush | input | 1 | Shift engine writes a received byte |
| rxPushData | input | 8 | Received byte |
| rxPop | input | 1 | Bus side reads a received byte |
| rxPopData | output | 8 | Last byte popped from the receive queue |
| txPush | input | 1 | Bus side writes a byte to send |
| txPushData | input | 8 | Byte to send |
| txPop | input | 1 | Shift engine takes a byte to send |
| txPopData | output | 8 | Last byte popped from the transmit queue |
| xferStart | input | 1 | Shift engine begins a transfer |
| statRead | input | 1 | Status word is being read; clears sticky flags |
| txMode | input | 1 | 0: completion judged on receive, 1: on transmit |
| rxMark | input | 3 | Receive watermark count |
| txMark | input | 3 | Transmit watermark count |
| rxFlush | input | 1 | Receive flush mode; masks the overflow interrupt |
| txFlush | input | 1 | Transmit flush mode; masks the underflow interrupt |
| statusWord | output | 16 | Packed status word |
| irq | output | 1 | Interrupt, equal to the global flag |

## Verification
A wrong fill count shows in the count fields and the excess bit in the next cycle. It also shows later as a wrong byte order or a missed overflow or underflow, once the queue runs against full or empty. A sticky flag that is set or cleared wrongly shows one cycle after the event or read that should have changed it, both on its status bit and on `irq`. Random push, pop, start and read traffic is therefore compared against a model on every cycle. The watermarks, mode and flush bits are changed periodically so that the mode-dependent completion and the masking are each reached.

// File: rtl/spi_fifo_status_pkg.sv
`timescale 1ns/1ps
package spi_fifo_status_pkg;

  // Effective queue strobes sent from control to datapath.
  typedef struct packed {
    logic rxWr;
    logic rxRd;
    logic txWr;
    logic txRd;
  } fifoStrobeT;

  localparam int STAT_W     = 16;
  localparam int CNT_FLD_W  = 3;
  localparam int ST_GLOBAL  = 0;
  localparam int ST_TXUNF   = 4;
  localparam int ST_TXIRQ   = 5;
  localparam int ST_RXIRQ   = 6;
  localparam int ST_RXOVF   = 7;
  localparam int ST_EXCESS  = 11;

endpackage

// File: rtl/spi_byte_fifo.sv
`timescale 1ns/1ps
module spi_byte_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wr,
  input  logic              rd,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [CNT_W-1:0]  cnt
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wPtr, rPtr;
  logic              bypass;

  assign bypass = wr && rd && (cnt == '0);

  function automatic logic [PTR_W-1:0] bumpPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (wr && !bypass) mem[wPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wPtr   <= '0;
      rPtr   <= '0;
      cnt    <= '0;
      rdData <= '0;
    end else if (bypass) begin
      rdData <= wrData;
    end else begin
      if (wr) wPtr <= bumpPtr(wPtr);
      if (rd) begin
        rdData <= mem[rPtr];
        rPtr   <= bumpPtr(rPtr);
      end
      cnt <= cnt + CNT_W'(wr) - CNT_W'(rd);
    end
  end

  // R2: control never writes into a full queue without a matching read
  p_no_overrun_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(wr && !rd && cnt == CNT_W'(DEPTH)));

  // R10: control never reads an empty queue without a bypass write
  p_no_underrun_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(rd && !wr && cnt == '0));

  // R10: an idle queue keeps its count and its output byte
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!wr && !rd) |=> ($stable(cnt) && $stable(rdData)));

endmodule

// File: rtl/spi_fifo_status_dp.sv
`timescale 1ns/1ps
module spi_fifo_status_dp
  import spi_fifo_status_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobeT        strobe,
  input  logic [DATA_W-1:0] rxPushData,
  input  logic [DATA_W-1:0] txPushData,
  output logic [DATA_W-1:0] rxPopData,
  output logic [DATA_W-1:0] txPopData,
  output logic [CNT_W-1:0]  rxCnt,
  output logic [CNT_W-1:0]  txCnt
);

  localparam int N_Q = 2;   // index 0 = receive, 1 = transmit

  logic [N_Q-1:0]    qWr, qRd;
  logic [DATA_W-1:0] qIn  [N_Q];
  logic [DATA_W-1:0] qOut [N_Q];
  logic [CNT_W-1:0]  qCnt [N_Q];

  assign qWr     = {strobe.txWr, strobe.rxWr};
  assign qRd     = {strobe.txRd, strobe.rxRd};
  assign qIn[0]  = rxPushData;
  assign qIn[1]  = txPushData;

  for (genvar g = 0; g < N_Q; g++) begin : g_queue
    spi_byte_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk    (clk),
      .rstN   (rstN),
      .wr     (qWr[g]),
      .rd     (qRd[g]),
      .wrData (qIn[g]),
      .rdData (qOut[g]),
      .cnt    (qCnt[g])
    );
  end

  assign rxPopData = qOut[0];
  assign txPopData = qOut[1];
  assign rxCnt     = qCnt[0];
  assign txCnt     = qCnt[1];

endmodule

// File: rtl/spi_fifo_status_ctl.sv
`timescale 1ns/1ps
module spi_fifo_status_ctl
  import spi_fifo_status_pkg::*;
#(
  parameter int DEPTH  = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxPush,
  input  logic              rxPop,
  input  logic              txPush,
  input  logic              txPop,
  input  logic              xferStart,
  input  logic              statRead,
  input  logic              txMode,
  input  logic [CNT_W-1:0]  rxMark,
  input  logic [CNT_W-1:0]  txMark,
  input  logic              rxFlush,
  input  logic              txFlush,
  input  logic [CNT_W-1:0]  rxCnt,
  input  logic [CNT_W-1:0]  txCnt,
  output fifoStrobeT        strobe,
  output logic [STAT_W-1:0] statusWord,
  output logic              irq
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [CNT_W-1:0] rxNext, txNext;
  logic ovfEvt, unfEvt, rxDoneEvt, txDoneEvt, srcEvt;
  logic ovfFlag, unfFlag, rxDoneFlag, txDoneFlag, globalFlag;
  logic excess;

  // Effective strobes: a push into full succeeds only with a pop,
  // a pop from empty succeeds only with a push (bypass).
  always_comb begin
    strobe.rxWr = rxPush && ((rxCnt != FULL) || rxPop);
    strobe.rxRd = rxPop  && ((rxCnt != '0)   || rxPush);
    strobe.txWr = txPush && ((txCnt != FULL) || txPop);
    strobe.txRd = txPop  && ((txCnt != '0)   || txPush);
  end

  assign rxNext = rxCnt + CNT_W'(strobe.rxWr) - CNT_W'(strobe.rxRd);
  assign txNext = txCnt + CNT_W'(strobe.txWr) - CNT_W'(strobe.txRd);

  always_comb begin
    ovfEvt    = rxPush && !rxPop && (rxCnt == FULL);
    unfEvt    = xferStart && (txCnt == '0);
    rxDoneEvt = !txMode && strobe.rxWr && (rxMark != '0) && (rxNext >= rxMark);
    txDoneEvt = txMode && strobe.txRd && (txNext <= txMark);
    srcEvt    = (ovfEvt && !rxFlush) || (unfEvt && !txFlush) || rxDoneEvt || txDoneEvt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ovfFlag    <= 1'b0;
      unfFlag    <= 1'b0;
      rxDoneFlag <= 1'b0;
      txDoneFlag <= 1'b0;
      globalFlag <= 1'b0;
    end else begin
      ovfFlag    <= ovfEvt    || (ovfFlag    && !statRead);
      unfFlag    <= unfEvt    || (unfFlag    && !statRead);
      rxDoneFlag <= rxDoneEvt || (rxDoneFlag && !statRead);
      txDoneFlag <= txDoneEvt || (txDoneFlag && !statRead);
      globalFlag <= srcEvt    || (globalFlag && !statRead);
    end
  end

  assign excess = rxCnt > rxMark;
  assign irq    = globalFlag;

  always_comb begin
    statusWord                  = '0;
    statusWord[ST_EXCESS]       = excess;
    statusWord[10:8]            = CNT_FLD_W'(rxCnt);
    statusWord[ST_RXOVF]        = ovfFlag;
    statusWord[ST_RXIRQ]        = rxDoneFlag;
    statusWord[ST_TXIRQ]        = txDoneFlag;
    statusWord[ST_TXUNF]        = unfFlag;
    statusWord[3:1]             = CNT_FLD_W'(txCnt);
    statusWord[ST_GLOBAL]       = globalFlag;
  end

  // R3: push into a full queue without a pop flags overflow, count stays full
  p_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rxPush && !rxPop && rxCnt == FULL) |=> (statusWord[ST_RXOVF] && rxCnt == FULL));

  // R4: start on an empty transmit queue flags underflow
  p_underflow_r4: assert property (@(posedge clk) disable iff (!rstN)
    (xferStart && txCnt == '0) |=> statusWord[ST_TXUNF]);

  // R7: draining the last transmit byte in transmit mode sets the done flag
  p_txdone_r7: assert property (@(posedge clk) disable iff (!rstN)
    (txMode && txPop && !txPush && txCnt == CNT_W'(1)) |=> statusWord[ST_TXIRQ]);

  // R9: a read with no possible set event clears all sticky bits
  p_read_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    (statRead && !rxPush && !txPop && !xferStart) |=> (statusWord[7:4] == 4'b0 && !irq));

  // R8: with both flush modes on and no done event possible, irq stays low
  p_flush_mask_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rxFlush && txFlush && !irq && !rxPush && !txPop) |=> !irq);

  // R2: the reserved top bits never show a one
  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[15:12] == 4'b0);

endmodule

// File: rtl/spi_fifo_status.sv
`timescale 1ns/1ps
module spi_fifo_status
  import spi_fifo_status_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxPush,
  input  logic [DATA_W-1:0] rxPushData,
  input  logic              rxPop,
  output logic [DATA_W-1:0] rxPopData,
  input  logic              txPush,
  input  logic [DATA_W-1:0] txPushData,
  input  logic              txPop,
  output logic [DATA_W-1:0] txPopData,
  input  logic              xferStart,
  input  logic              statRead,
  input  logic              txMode,
  input  logic [CNT_W-1:0]  rxMark,
  input  logic [CNT_W-1:0]  txMark,
  input  logic              rxFlush,
  input  logic              txFlush,
  output logic [STAT_W-1:0] statusWord,
  output logic              irq
);

  fifoStrobeT       strobe;
  logic [CNT_W-1:0] rxCnt, txCnt;

  spi_fifo_status_ctl #(.DEPTH(DEPTH)) u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .rxPush     (rxPush),
    .rxPop      (rxPop),
    .txPush     (txPush),
    .txPop      (txPop),
    .xferStart  (xferStart),
    .statRead   (statRead),
    .txMode     (txMode),
    .rxMark     (rxMark),
    .txMark     (txMark),
    .rxFlush    (rxFlush),
    .txFlush    (txFlush),
    .rxCnt      (rxCnt),
    .txCnt      (txCnt),
    .strobe     (strobe),
    .statusWord (statusWord),
    .irq        (irq)
  );

  spi_fifo_status_dp #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .rxPushData (rxPushData),
    .txPushData (txPushData),
    .rxPopData  (rxPopData),
    .txPopData  (txPopData),
    .rxCnt      (rxCnt),
    .txCnt      (txCnt)
  );

endmodule

// File: tb/sim_spi_fifo_status.sv
`timescale 1ns/1ps
module sim_spi_fifo_status;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxPush = 0, rxPop = 0, txPush = 0, txPop = 0, xferStart = 0, statRead = 0;
  logic [7:0] rxPushData = 0, txPushData = 0;
  logic [7:0] rxPopData, txPopData;
  logic txMode = 0, rxFlush = 0, txFlush = 0;
  logic [2:0] rxMark = 3'd2, txMark = 3'd1;
  logic [15:0] statusWord;
  logic irq;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  always #10 clk = ~clk;   // 50 MHz

  spi_fifo_status u0 (
    .clk(clk), .rstN(rstN),
    .rxPush(rxPush), .rxPushData(rxPushData), .rxPop(rxPop), .rxPopData(rxPopData),
    .txPush(txPush), .txPushData(txPushData), .txPop(txPop), .txPopData(txPopData),
    .xferStart(xferStart), .statRead(statRead), .txMode(txMode),
    .rxMark(rxMark), .txMark(txMark), .rxFlush(rxFlush), .txFlush(txFlush),
    .statusWord(statusWord), .irq(irq)
  );

  // ---------------- reference model ----------------
  logic [7:0] mRxQ [4];
  logic [7:0] mTxQ [4];
  int mRxN, mTxN;
  logic mOvf, mUnf, mRxDone, mTxDone, mGlob;
  logic [7:0] mRxOut, mTxOut;

  task automatic modelReset();
    mRxN = 0; mTxN = 0;
    mOvf = 0; mUnf = 0; mRxDone = 0; mTxDone = 0; mGlob = 0;
    mRxOut = 0; mTxOut = 0;
  endtask

  // queue update; returns accepted write/read flags
  task automatic queueStep(inout logic [7:0] q [4], inout int n, inout logic [7:0] outB,
                           input logic push, input logic pop, input logic [7:0] d,
                           output bit wrOk, output bit rdOk);
    wrOk = push && (n < 4 || pop);
    rdOk = pop && (n > 0 || push);
    if (wrOk && rdOk && n == 0) begin
      outB = d;
    end else begin
      if (rdOk) begin
        outB = q[0];
        for (int i = 0; i < 3; i++) q[i] = q[i+1];
        n--;
      end
      if (wrOk) begin
        q[n] = d;
        n++;
      end
    end
  endtask

  task automatic modelStep();
    bit rxW, rxR, txW, txR;
    int rxOld, txOld;
    logic ovfE, unfE, rxE, txE, srcE;
    rxOld = mRxN; txOld = mTxN;
    queueStep(mRxQ, mRxN, mRxOut, rxPush, rxPop, rxPushData, rxW, rxR);
    queueStep(mTxQ, mTxN, mTxOut, txPush, txPop, txPushData, txW, txR);
    ovfE = rxPush && !rxPop && rxOld == 4;
    unfE = xferStart && txOld == 0;
    rxE  = !txMode && rxW && rxMark != 0 && mRxN >= int'(rxMark);
    txE  = txMode && txR && mTxN <= int'(txMark);
    srcE = (ovfE && !rxFlush) || (unfE && !txFlush) || rxE || txE;
    mOvf    = ovfE || (mOvf    && !statRead);
    mUnf    = unfE || (mUnf    && !statRead);
    mRxDone = rxE  || (mRxDone && !statRead);
    mTxDone = txE  || (mTxDone && !statRead);
    mGlob   = srcE || (mGlob   && !statRead);
  endtask

  function automatic logic [15:0] modelStatus();
    logic [15:0] s;
    s = '0;
    s[11]   = mRxN > int'(rxMark);
    s[10:8] = 3'(mRxN);
    s[7]    = mOvf;
    s[6]    = mRxDone;
    s[5]    = mTxDone;
    s[4]    = mUnf;
    s[3:1]  = 3'(mTxN);
    s[0]    = mGlob;
    return s;
  endfunction

  // ---------------- check helpers ----------------
  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compareModel();
    check("R2,R9 status word vs model", statusWord, modelStatus());
    check("R8 irq vs model", 16'(irq), 16'(mGlob));
    check("R11 rx pop data vs model", 16'(rxPopData), 16'(mRxOut));
    check("R11 tx pop data vs model", 16'(txPopData), 16'(mTxOut));
  endtask

  task automatic drive(input logic [5:0] c, input logic [7:0] d);
    {statRead, xferStart, txPop, txPush, rxPop, rxPush} = c;
    rxPushData = d;
    txPushData = d;
  endtask

  task automatic tick();
    modelStep();
    @(posedge clk);
    #2;
    compareModel();
    drive(6'h00, 8'h00);
  endtask

  // control encoding: bit0 rxPush, bit1 rxPop, bit2 txPush, bit3 txPop,
  // bit4 xferStart, bit5 statRead; config txMode=0 rxMark=2 txMark=1
  localparam int NVEC = 15;
  localparam logic [29:0] VEC [NVEC] = '{
    {6'h00, 8'h00, 16'h0000},
    {6'h01, 8'hA1, 16'h0100},
    {6'h01, 8'hA2, 16'h0241},
    {6'h01, 8'hA3, 16'h0B41},
    {6'h01, 8'hA4, 16'h0C41},
    {6'h01, 8'hA5, 16'h0CC1},
    {6'h20, 8'h00, 16'h0C00},
    {6'h02, 8'h00, 16'h0B00},
    {6'h04, 8'hB1, 16'h0B02},
    {6'h10, 8'h00, 16'h0B02},
    {6'h08, 8'h00, 16'h0B00},
    {6'h10, 8'h00, 16'h0B11},
    {6'h30, 8'h00, 16'h0B11},
    {6'h20, 8'h00, 16'h0B00},
    {6'h02, 8'h00, 16'h0200}
  };

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    #(20ns * 200000);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual running expected finished");
    finish();
  end

  initial begin
    modelReset();
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state
    check("R1 status after reset", statusWord, 16'h0000);
    check("R1 irq after reset", 16'(irq), 16'h0000);
    check("R1 rx pop data after reset", 16'(rxPopData), 16'h0000);
    check("R1 tx pop data after reset", 16'(txPopData), 16'h0000);
    rstN = 1'b1;

    // table walk: counts, excess, overflow, underflow, rx done, read clear
    for (int v = 0; v < NVEC; v++) begin
      drive(VEC[v][29:24], VEC[v][23:16]);
      tick();
      check($sformatf("R3,R4,R5,R6,R9 table vector %0d", v), statusWord, VEC[v][15:0]);
    end

    // R8: overflow under receive flush mode does not raise irq
    txMode = 1; rxFlush = 1;
    drive(6'h01, 8'hC1); tick();
    drive(6'h01, 8'hC2); tick();
    drive(6'h01, 8'hC3); tick();
    check("R8 flush overflow bit7 set", 16'(statusWord[7]), 16'h0001);
    check("R8 flush overflow irq low", 16'(irq), 16'h0000);
    check("R2 rx count saturates at 4", 16'(statusWord[10:8]), 16'h0004);
    drive(6'h20, 8'h00); tick();
    rxFlush = 0;

    // R7: transmit done when the queue drains to the watermark
    txMark = 3'd0;
    drive(6'h04, 8'hD1); tick();
    drive(6'h04, 8'hD2); tick();
    drive(6'h08, 8'h00); tick();
    check("R7 tx done not yet", 16'(statusWord[5]), 16'h0000);
    check("R11 first tx byte", 16'(txPopData), 16'h00D1);
    drive(6'h08, 8'h00); tick();
    check("R7 tx done set", 16'(statusWord[5]), 16'h0001);
    check("R8 irq on tx done", 16'(irq), 16'h0001);
    check("R11 second tx byte", 16'(txPopData), 16'h00D2);
    drive(6'h20, 8'h00); tick();

    // R10, R11: drain rx (A3,A4,C1,C2), pop empty, bypass
    for (int i = 0; i < 4; i++) begin drive(6'h02, 8'h00); tick(); end
    check("R11 last rx byte in order", 16'(rxPopData), 16'h00C2);
    drive(6'h02, 8'h00); tick();
    check("R10 pop empty holds data", 16'(rxPopData), 16'h00C2);
    check("R10 pop empty count 0", 16'(statusWord[10:8]), 16'h0000);
    drive(6'h03, 8'hE1); tick();
    check("R10 bypass data", 16'(rxPopData), 16'h00E1);
    check("R10 bypass count 0", 16'(statusWord[10:8]), 16'h0000);

    // R5, R6: watermark 0 gives excess but no receive done
    txMode = 0; rxMark = 3'd0;
    drive(6'h20, 8'h00); tick();
    drive(6'h01, 8'hF1); tick();
    check("R6 zero watermark no rx done", 16'(statusWord[6]), 16'h0000);
    check("R5 excess above zero watermark", 16'(statusWord[11]), 16'h0001);

    // random traffic against the model
    for (int c = 0; c < 4000; c++) begin
      if (c % 250 == 0) begin
        txMode  = 1'($urandom);
        rxMark  = 3'($urandom_range(0, 4));
        txMark  = 3'($urandom_range(0, 4));
        rxFlush = 1'($urandom);
        txFlush = 1'($urandom);
      end
      drive({($urandom_range(0, 7) == 0), ($urandom_range(0, 3) == 0),
             1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom)},
            8'($urandom));
      tick();
    end

    finish();
  end

endmodule